// File: doc/BRIEF.md
# Memory-Cycle Signal Sequencer

The sequencer plays back a short program of control words toward an external memory device. Each word lasts one memory cycle, which is split into four quarter phases T1, T2, T3 and T4. Each phase takes one clock of the block. A word sets four strobe lines. Each line gets one level that is applied from T1 and held through T2, and a second level that is applied from T3 and held through T4. A read flag in the word makes the block emit a one-clock data-sample pulse, and a last flag ends the program.

The host fills the 64-entry word store while the sequencer is idle. It then pulses `start` with a start address. The words run in address order, and the address wraps after the top entry. A mode input changes the role of the fourth strobe line: it becomes an external wait input, and the two word bits that held its levels become a sample-phase select and a wait enable. The wait input passes through a two-flop synchroniser. While an enabled wait is active, the phase counter stalls and every output holds its value.

Top module: `mcs_sequencer`

## Requirements
- R1: A word is 10 bits. Bits [3:0] give the first-half levels of lines 0..3, bits [7:4] give their second-half levels, bit 8 is the read flag and bit 9 is the last flag. While busy, `gp_out` shows the first-half levels during T1 and T2 and the second-half levels during T3 and T4. The phase after a start is T1, and each following clock advances one phase.
- R2: With `wait_mode` = 0, line 3 is an ordinary strobe output driven from bits 3 and 7.
- R3: With `wait_mode` = 1, `gp_out[3]` stays at `idle_level[3]`. Bit 3 selects the sample phase of a read word: 0 puts the pulse in T1 and 1 puts it in T3.
- R4: A word with bit 8 clear produces no sample pulse. With `wait_mode` = 0, a read word pulses in T3.
- R5: With `wait_mode` = 1 and bit 7 of the current word clear, `wait_in` has no effect on outputs or timing.
- R6: With `wait_mode` = 1 and bit 7 set, a synchronised wait stalls the phase and word address, and all outputs hold. The sequence resumes from the same phase once the wait is released. If `wait_in` first changes during cycle c, the change takes effect in cycle c+2.
- R7: No sample pulse is issued while frozen, so each read word gives exactly one pulse.
- R8: After the T4 of a word with bit 9 set, `busy` falls, `done` is high for exactly one clock, and `gp_out` returns to `idle_level`.
- R9: Host writes and `start` pulses are ignored while busy.
- R10: The sequence begins at `start_addr`. The address steps by one per word and wraps from 63 to 0.
- R11: After reset, `busy`, `done` and `sample_pulse` are 0 and `gp_out` equals `idle_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host word write strobe |
| host_addr | input | 6 | Host write address |
| host_wdata | input | 10 | Host write word |
| start | input | 1 | Start a sequence when idle |
| start_addr | input | 6 | First word of the sequence |
| wait_mode | input | 1 | 1: line 3 acts as wait input |
| wait_in | input | 1 | External wait, asynchronous |
| idle_level | input | 4 | Strobe levels when idle |
| gp_out | output | 4 | Strobe lines |
| sample_pulse | output | 1 | Read data sample strobe |
| done | output | 1 | One-clock end-of-sequence flag |
| busy | output | 1 | Sequence running |

## Verification
The programs mix read and write words with distinct first-half and second-half levels in each of the two line-3 modes. This separates a T1/T3 swap, a mishandled line 3, and a sample pulse in the wrong phase or on a write. The wait input is asserted over words that have wait enable clear, which proves it is ignored. It is also asserted over words that have it set, once across a word boundary and once across the sample phase. This exposes a wrong synchroniser latency, a phase that skips on release, and a pulse that is doubled or lost. A run that wraps past address 63, with an intruding host write and start mid-run, tells apart address wrap faults and missing busy guards.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int LINES  = 4;
    localparam int WORD_W = 2 * LINES + 2;

    typedef enum logic [1:0] {
        PH_T1 = 2'd0,
        PH_T2 = 2'd1,
        PH_T3 = 2'd2,
        PH_T4 = 2'd3
    } phase_t;

    typedef struct packed {
        logic             last;
        logic             rd;
        logic [LINES-1:0] late;
        logic [LINES-1:0] early;
    } ctl_word_t;

    function automatic phase_t phase_next(phase_t p);
        case (p)
            PH_T1:   return PH_T2;
            PH_T2:   return PH_T3;
            PH_T3:   return PH_T4;
            default: return PH_T1;
        endcase
    endfunction

    function automatic logic in_first_half(phase_t p);
        return (p == PH_T1) || (p == PH_T2);
    endfunction
endpackage

// File: rtl/mcs_word_ram.sv
module mcs_word_ram
    import mcs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      we,
    input  logic [AW-1:0] waddr,
    input  ctl_word_t wdata,
    input  logic [AW-1:0] raddr,
    output ctl_word_t rdata
);
    ctl_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mcs_wait_sync.sv
module mcs_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mcs_phase_ctl.sv
module mcs_phase_ctl
    import mcs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          freeze,
    input  logic          word_last,
    output logic          busy,
    output phase_t        phase,
    output logic [AW-1:0] addr,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= PH_T1;
            addr  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    addr  <= start_addr;
                    phase <= PH_T1;
                end
            end else if (!freeze) begin
                phase <= phase_next(phase);
                if (phase == PH_T4) begin
                    if (word_last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
    import mcs_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int AW          = $clog2(DEPTH),
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic              wait_mode,
    input  logic              wait_in,
    input  logic [LINES-1:0]  idle_level,
    output logic [LINES-1:0]  gp_out,
    output logic              sample_pulse,
    output logic              done,
    output logic              busy
);
    localparam int TOP = LINES - 1;

    ctl_word_t     word;
    phase_t        phase;
    logic [AW-1:0] addr;
    logic          wait_s;
    logic          freeze;
    phase_t        sample_phase;

    mcs_word_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (host_we && !busy),
        .waddr (host_addr),
        .wdata (ctl_word_t'(host_wdata)),
        .raddr (addr),
        .rdata (word)
    );

    mcs_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (wait_in),
        .dout (wait_s)
    );

    // Line 3's late bit doubles as the wait enable in wait mode.
    assign freeze = busy && wait_mode && word.late[TOP] && wait_s;

    mcs_phase_ctl #(.AW(AW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .freeze     (freeze),
        .word_last  (word.last),
        .busy       (busy),
        .phase      (phase),
        .addr       (addr),
        .done       (done)
    );

    always_comb begin
        if (!busy) begin
            gp_out = idle_level;
        end else begin
            gp_out = in_first_half(phase) ? word.early : word.late;
            if (wait_mode) gp_out[TOP] = idle_level[TOP];
        end
    end

    // Line 3's early bit doubles as the sample-phase select in wait mode.
    assign sample_phase = (wait_mode && !word.early[TOP]) ? PH_T1 : PH_T3;
    assign sample_pulse = busy && word.rd && !freeze && (phase == sample_phase);
endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk
    import mcs_pkg::*;
#(
    parameter int AW = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             freeze,
    input logic [1:0]       phase,
    input logic [AW-1:0]    addr,
    input logic [LINES-1:0] gp_out,
    input logic [LINES-1:0] idle_level,
    input logic             sample_pulse
);
    p_freeze_stalls_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && freeze) |=> (busy && $stable(phase) && $stable(addr)));

    p_no_sample_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        sample_pulse |-> (busy && !freeze));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && gp_out == idle_level));

    p_start_loads_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && phase == 2'd0));

    p_addr_step_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !freeze && phase == 2'd3) |=> (!busy || addr == AW'($past(addr) + 1'b1)));

    p_half_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (phase == 2'd1 || phase == 2'd3)) |-> $stable(gp_out));
endmodule

bind mcs_sequencer mcs_sequencer_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .freeze       (freeze),
    .phase        (phase),
    .addr         (addr),
    .gp_out       (gp_out),
    .idle_level   (idle_level),
    .sample_pulse (sample_pulse)
);

// File: tb/test_mcs_sequencer.sv
`timescale 1ns/1ps
module test_mcs_sequencer;
    typedef struct {
        logic [3:0] gp;
        logic       smp;
        logic       dn;
        logic       bsy;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic [9:0] host_wdata = '0;
    logic       start = 1'b0;
    logic [5:0] start_addr = '0;
    logic       wait_mode = 1'b0;
    logic       wait_in = 1'b0;
    logic [3:0] idle_level = 4'b1010;
    logic [3:0] gp_out;
    logic       sample_pulse, done, busy;

    int checks = 0;
    int failures = 0;
    logic mon_on = 1'b0;
    int cyc = 0;
    item_t exp_q[$];
    logic [9:0] img [64];

    mcs_sequencer i_mcs_sequencer (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .start(start), .start_addr(start_addr),
        .wait_mode(wait_mode), .wait_in(wait_in), .idle_level(idle_level),
        .gp_out(gp_out), .sample_pulse(sample_pulse), .done(done), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    // Monitor: compares each cycle's outputs against the scoreboard head.
    always @(negedge clk) begin
        #1;
        if (mon_on && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(it.tag, $sformatf("gp_out c%0d", cyc), gp_out, it.gp);
            check(it.tag, $sformatf("sample c%0d", cyc), sample_pulse, it.smp);
            check(it.tag, $sformatf("done c%0d", cyc), done, it.dn);
            check(it.tag, $sformatf("busy c%0d", cyc), busy, it.bsy);
            cyc++;
        end
    end

    task automatic wr(input int a, input logic [9:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 6'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        img[a] = d;
    endtask

    // Driver: predicts every cycle from the requirements, then stimulates.
    task automatic run_seq(input int sa, input logic wm, input int w0, input int wl,
                           input logic intr, input string tag);
        int idx = sa;
        int ph = 0;
        int c = 0;
        int n;
        bit fin = 0;
        while (!fin && c < 1000) begin
            item_t it;
            logic [9:0] w = img[idx];
            bit frz = wm && w[7] && (c >= w0 + 2) && (c < w0 + wl + 2);
            int sp = wm ? (w[3] ? 2 : 0) : 2;
            it.gp  = (ph < 2) ? w[3:0] : w[7:4];
            if (wm) it.gp[3] = idle_level[3];
            it.smp = w[8] && !frz && (ph == sp);
            it.dn  = 1'b0;
            it.bsy = 1'b1;
            it.tag = tag;
            exp_q.push_back(it);
            if (!frz) begin
                if (ph == 3) begin
                    ph = 0;
                    if (w[9]) fin = 1;
                    else idx = (idx + 1) % 64;
                end else ph++;
            end
            c++;
        end
        begin
            item_t it;
            it.gp = idle_level; it.smp = 0; it.dn = 1; it.bsy = 0; it.tag = tag;
            exp_q.push_back(it);
            it.dn = 0;
            exp_q.push_back(it);
        end
        n = exp_q.size();
        wait_mode = wm;
        @(negedge clk);
        start = 1'b1; start_addr = 6'(sa);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        mon_on = 1'b1;
        for (int k = 0; k < n; k++) begin
            wait_in = (k >= w0) && (k < w0 + wl);
            if (intr) begin
                if (k == 1) begin host_we = 1'b1; host_addr = 6'd1; host_wdata = ~img[1]; end
                if (k == 2) begin host_we = 1'b0; start = 1'b1; start_addr = 6'd10; end
                if (k == 3) start = 1'b0;
            end
            @(negedge clk);
        end
        wait (exp_q.size() == 0);
        mon_on = 1'b0;
        wait_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R11: reset state
        check("R11", "gp_out", gp_out, idle_level);
        check("R11", "busy", busy, 0);
        check("R11", "done", done, 0);
        check("R11", "sample", sample_pulse, 0);

        // Output-mode program at 0..3: layout, line 3 as strobe, last word
        wr(0, 10'b01_0110_1001);
        wr(1, 10'b00_1111_0000);
        wr(2, 10'b00_0000_1111);
        wr(3, 10'b11_1010_0101);
        run_seq(0, 1'b0, -100, 0, 1'b0, "R1 R2 R4 R8 R10");

        // Wait-mode program at 10..12: sample select T1, T3, and a write
        wr(10, 10'b01_0011_0101);
        wr(11, 10'b01_0101_1010);
        wr(12, 10'b10_0110_1001);
        run_seq(10, 1'b1, -100, 0, 1'b0, "R3 R4");
        // R5: wait asserted over words with wait enable clear
        run_seq(10, 1'b1, 1, 6, 1'b0, "R5");

        // Freeze program at 20..21 with wait enable set
        wr(20, 10'b01_1000_0001);
        wr(21, 10'b11_1001_1110);
        run_seq(20, 1'b1, 1, 3, 1'b0, "R6 R7 boundary");
        run_seq(20, 1'b1, 4, 2, 1'b0, "R6 R7 sample-phase");

        // R9 R10: wrap 62 -> 63 -> 0..3 with intruding write and start
        idle_level = 4'b0101;
        wr(62, 10'b00_0001_0010);
        wr(63, 10'b01_0100_1000);
        run_seq(62, 1'b0, -100, 0, 1'b1, "R9 R10 wrap");
        // R9: word 1 must still hold its original value
        run_seq(0, 1'b0, -100, 0, 1'b0, "R9 readback");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule